// File: doc/BRIEF.md
# Crosspoint Configuration Slave on a Two-Wire Bus

This block is a write-only two-wire bus (I2C) slave that holds the settings of a video crosspoint with six inputs and eight outputs, and drives the control lines of that crosspoint. A bus master addresses the slave and then sends a stream of data bytes. Bit 0 of each byte gives its type. A pointer byte picks one of the eight outputs. A setting byte then writes that output's source input, its gain, its Y/C mixer enable and its high-impedance drive, and it also sets the clamp mode of the input it names. Two strap pins set the low address bits, so four slaves can share one bus.

SCL and SDA are sampled on the system clock through a synchronizer, which detects SCL edges, START and STOP. A receive state machine works on those events. Its states are: `S_IDLE` (no transfer), `S_ADDR` (shifting the address byte), `S_AACK` (driving ACK for the address), `S_DATA` (shifting a data byte), `S_DACK` (driving ACK for a data byte) and `S_SKIP` (addressed to another device, waiting for the bus to free). The transitions are:
- A START moves any state to `S_ADDR`, and a STOP moves any state to `S_IDLE`.
- In `S_ADDR`, the SCL fall after the eighth bit goes to `S_AACK` on a match and to `S_SKIP` otherwise.
- `S_AACK` goes to `S_DATA` on the next SCL fall.
- In `S_DATA`, the SCL fall after the eighth bit hands the byte to the register bank and goes to `S_DACK`.
- `S_DACK` returns to `S_DATA` on the next SCL fall.

Top module: `xpoint_i2c_ctrl`

## Requirements
- R1: The slave acknowledges an address byte equal to {1,0,0,1,0, addr_strap[1], addr_strap[0], 0}, which gives 0x90, 0x92, 0x94 or 0x96. It holds sda_oe high for that ACK bit.
- R2: The slave does not acknowledge any other address byte, including its own address with the read bit set. Data bytes that follow in that transfer get no ACK and change no output.
- R3: After an acknowledged address, every data byte is acknowledged, and any number of data bytes may follow in one transfer.
- R4: A data byte with bit 0 = 0 is a pointer byte. Bits 7:5 select output 0 to 7, and the byte changes no control output.
- R5: A data byte with bit 0 = 1 is a setting byte. Bits 7:5 with codes 0 to 5 load the source select of the pointed output, src_sel[3*o+2:3*o], with that input index.
- R6: In a setting byte, bit 3 loads gain_hi of the pointed output (1 = high gain) and bit 1 loads out_hiz (1 = high impedance).
- R7: In a setting byte, bit 4 loads clamp_en of the input named by bits 7:5 (1 = clamped, 0 = free-running).
- R8: A setting byte with code 6 or 7 in bits 7:5 leaves the source select and every clamp_en bit unchanged, but still applies bits 3, 2 and 1.
- R9: Bit 2 of a setting byte loads mix_en only when the pointed output is 6 or 7. For outputs 0 to 5, mix_en stays 0.
- R10: A START or STOP, including one in the middle of a byte, returns the parser to waiting for an address. It discards partial bits but keeps the output pointer.
- R11: After reset, out_hiz and clamp_en are all ones, src_sel, gain_hi and mix_en are all zeros, the pointer is 0 and sda_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| addr_strap | input | 2 | Low address bits {A1, A0} |
| sda_oe | output | 1 | Pulls SDA low when 1 (ACK) |
| src_sel | output | 24 | Source input per output, 3 bits each, output 0 in bits 2:0 |
| gain_hi | output | 8 | High-gain select per output |
| mix_en | output | 8 | Y/C mixer enable per output |
| out_hiz | output | 8 | High-impedance drive per output |
| clamp_en | output | 6 | Clamp mode per input |

## Verification
The assertions assume the master changes SDA only while SCL is low, except for START and STOP. They also assume SCL stays low for several system clocks after each fall, so the slave's ACK always starts while the raw SCL line is low. The bench drives every bus phase as ten system clocks and never moves SCL and SDA in the same phase, which meets both assumptions. It compares all control outputs each cycle against a behavioural model that is updated when each acknowledged data byte completes.

// File: rtl/xp_pkg.sv
package xp_pkg;
    localparam int N_OUT = 8;
    localparam int N_IN  = 6;
    localparam int SEL_W = $clog2(N_OUT);
    localparam int CNT_W = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_DATA,
        S_DACK,
        S_SKIP
    } rx_state_t;
endpackage

// File: rtl/xp_i2c_sync.sv
module xp_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);
    localparam int LAST = STAGES;

    logic [LAST:0] scl_p;
    logic [LAST:0] sda_p;
    logic scl_cur, scl_old, sda_cur, sda_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
        end else begin
            scl_p <= {scl_p[LAST-1:0], scl_i};
            sda_p <= {sda_p[LAST-1:0], sda_i};
        end
    end

    assign scl_cur = scl_p[LAST-1];
    assign scl_old = scl_p[LAST];
    assign sda_cur = sda_p[LAST-1];
    assign sda_old = sda_p[LAST];

    assign scl_rise  = scl_cur & ~scl_old;
    assign scl_fall  = ~scl_cur & scl_old;
    assign start_det = scl_cur & scl_old & sda_old & ~sda_cur;
    assign stop_det  = scl_cur & scl_old & ~sda_old & sda_cur;
    assign sda_bit   = sda_cur;
endmodule

// File: rtl/xp_i2c_wr_fsm.sv
module xp_i2c_wr_fsm
    import xp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_bit,
    input  logic [7:0] dev_addr,
    output logic       sda_oe,
    output logic       byte_vld,
    output logic [7:0] byte_q
);
    rx_state_t        state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       shreg;
    logic             byte_done;
    logic             shifting;

    assign byte_done = scl_fall && (bit_cnt == CNT_W'(8));
    assign shifting  = (state == S_ADDR) || (state == S_DATA);

    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = S_IDLE;
        end else if (start_det) begin
            state_nx = S_ADDR;
        end else begin
            unique case (state)
                S_IDLE, S_SKIP: state_nx = state;
                S_ADDR: if (byte_done) state_nx = (shreg == dev_addr) ? S_AACK : S_SKIP;
                S_AACK: if (scl_fall) state_nx = S_DATA;
                S_DATA: if (byte_done) state_nx = S_DACK;
                S_DACK: if (scl_fall) state_nx = S_DATA;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= (state == S_DATA) && byte_done && !start_det && !stop_det;
            if (byte_done && state == S_DATA) byte_q <= shreg;
            if (start_det || stop_det ||
                (scl_fall && (state == S_AACK || state == S_DACK))) begin
                bit_cnt <= '0;
            end else if (scl_rise && shifting && bit_cnt != CNT_W'(8)) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[6:0], sda_bit};
            end
        end
    end

    always_comb begin
        sda_oe = (state == S_AACK) || (state == S_DACK);
    end
endmodule

// File: rtl/xp_cfg_regs.sv
module xp_cfg_regs
    import xp_pkg::*;
#(
    parameter logic [N_OUT-1:0] MIX_MASK = 8'hC0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   byte_vld,
    input  logic [7:0]             byte_q,
    output logic [SEL_W-1:0]       ptr,
    output logic [N_OUT*SEL_W-1:0] src_sel,
    output logic [N_OUT-1:0]       gain_hi,
    output logic [N_OUT-1:0]       mix_en,
    output logic [N_OUT-1:0]       out_hiz,
    output logic [N_IN-1:0]        clamp_en
);
    logic             is_ptr, is_set, src_ok;
    logic [SEL_W-1:0] code;

    assign code   = byte_q[7:5];
    assign is_ptr = byte_vld & ~byte_q[0];
    assign is_set = byte_vld & byte_q[0];
    assign src_ok = int'(code) < N_IN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr <= '0;
        else if (is_ptr) ptr <= code;
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [SEL_W-1:0] src_q;
        logic             gain_q, hiz_q, hit;
        assign hit = is_set && (ptr == SEL_W'(o));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q  <= '0;
                gain_q <= 1'b0;
                hiz_q  <= 1'b1;
            end else if (hit) begin
                if (src_ok) src_q <= code;
                gain_q <= byte_q[3];
                hiz_q  <= byte_q[1];
            end
        end

        if (MIX_MASK[o]) begin : g_mix
            logic mix_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   mix_q <= 1'b0;
                else if (hit) mix_q <= byte_q[2];
            end
            assign mix_en[o] = mix_q;
        end else begin : g_nomix
            assign mix_en[o] = 1'b0;
        end

        assign src_sel[o*SEL_W +: SEL_W] = src_q;
        assign gain_hi[o] = gain_q;
        assign out_hiz[o] = hiz_q;
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        logic clamp_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clamp_q <= 1'b1;
            else if (is_set && src_ok && code == SEL_W'(i)) clamp_q <= byte_q[4];
        end
        assign clamp_en[i] = clamp_q;
    end
endmodule

// File: rtl/xpoint_i2c_ctrl.sv
module xpoint_i2c_ctrl
    import xp_pkg::*;
#(
    parameter logic [4:0]       ADDR_HI     = 5'b10010,
    parameter logic [N_OUT-1:0] MIX_MASK    = 8'hC0,
    parameter int               SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic [1:0]             addr_strap,
    output logic                   sda_oe,
    output logic [N_OUT*SEL_W-1:0] src_sel,
    output logic [N_OUT-1:0]       gain_hi,
    output logic [N_OUT-1:0]       mix_en,
    output logic [N_OUT-1:0]       out_hiz,
    output logic [N_IN-1:0]        clamp_en
);
    logic             scl_rise, scl_fall, start_det, stop_det, sda_bit;
    logic             byte_vld;
    logic [7:0]       byte_q;
    logic [7:0]       dev_addr;
    logic [SEL_W-1:0] ptr;

    assign dev_addr = {ADDR_HI, addr_strap, 1'b0};

    xp_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit)
    );

    xp_i2c_wr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
        .dev_addr(dev_addr), .sda_oe(sda_oe), .byte_vld(byte_vld), .byte_q(byte_q)
    );

    xp_cfg_regs #(.MIX_MASK(MIX_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_q(byte_q),
        .ptr(ptr), .src_sel(src_sel), .gain_hi(gain_hi), .mix_en(mix_en),
        .out_hiz(out_hiz), .clamp_en(clamp_en)
    );
endmodule

// File: rtl/xpoint_i2c_ctrl_sva.sv
module xpoint_i2c_ctrl_sva
    import xp_pkg::*;
#(
    parameter logic [N_OUT-1:0] MIX_MASK = 8'hC0
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_i,
    input logic                   sda_oe,
    input logic                   byte_vld,
    input logic [7:0]             byte_q,
    input logic [SEL_W-1:0]       ptr,
    input logic [N_OUT*SEL_W-1:0] src_sel,
    input logic [N_OUT-1:0]       gain_hi,
    input logic [N_OUT-1:0]       mix_en,
    input logic [N_OUT-1:0]       out_hiz,
    input logic [N_IN-1:0]        clamp_en
);
    // R1, R3: the ACK is driven only into the low phase of SCL
    a_r3_ack_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R2: without a completed data byte nothing in the configuration moves
    a_r2_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable({src_sel, gain_hi, mix_en, out_hiz, clamp_en}) && $stable(ptr));

    // R4: a pointer byte leaves every control output alone
    a_r4_ptr_no_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_q[0]) |=> $stable({src_sel, gain_hi, mix_en, out_hiz, clamp_en}));

    // R5: a setting byte never moves the pointer
    a_r5_set_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_q[0]) |=> $stable(ptr));

    // R8: reserved source codes keep source selects and clamps
    a_r8_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && byte_q[0] && byte_q[7:6] == 2'b11) |=> $stable(src_sel) && $stable(clamp_en));

    // R9: mixer enables exist only on the designated outputs
    a_r9_mix_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (mix_en & ~MIX_MASK) == '0);
endmodule

bind xpoint_i2c_ctrl xpoint_i2c_ctrl_sva #(.MIX_MASK(MIX_MASK)) u_sva (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .byte_vld(byte_vld), .byte_q(byte_q), .ptr(ptr), .src_sel(src_sel),
    .gain_hi(gain_hi), .mix_en(mix_en), .out_hiz(out_hiz), .clamp_en(clamp_en)
);

// File: tb/tb_xpoint_i2c_ctrl.sv
module tb_xpoint_i2c_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 10;
    localparam int ACK_WAIT   = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_d = 1'b1;
    logic        sda_d = 1'b1;
    logic        sda_line;
    logic [1:0]  strap = 2'b00;
    logic        sda_oe;
    logic [23:0] src_sel;
    logic [7:0]  gain_hi, mix_en, out_hiz;
    logic [5:0]  clamp_en;

    int tests = 0;
    int fails = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    int m_ptr;
    int m_src[8];
    int m_gain[8];
    int m_mix[8];
    int m_hiz[8];
    int m_clamp[6];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_d & ~sda_oe;

    xpoint_i2c_ctrl dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_line),
        .addr_strap(strap), .sda_oe(sda_oe), .src_sel(src_sel),
        .gain_hi(gain_hi), .mix_en(mix_en), .out_hiz(out_hiz), .clamp_en(clamp_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_ptr = 0;
        for (int k = 0; k < 8; k++) begin
            m_src[k] = 0; m_gain[k] = 0; m_mix[k] = 0; m_hiz[k] = 1;
        end
        for (int k = 0; k < 6; k++) m_clamp[k] = 1;
    endfunction

    function automatic void model_byte(input logic [7:0] b);
        int c;
        c = int'(b[7:5]);
        if (b[0] == 1'b0) begin
            m_ptr = c;
        end else begin
            if (c < 6) begin
                m_src[m_ptr] = c;
                m_clamp[c] = int'(b[4]);
            end
            m_gain[m_ptr] = int'(b[3]);
            m_hiz[m_ptr]  = int'(b[1]);
            if (m_ptr == 6 || m_ptr == 7) m_mix[m_ptr] = int'(b[2]);
        end
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en && rst_n && !done) begin
            logic [23:0] e_src;
            logic [7:0]  e_gain, e_mix, e_hiz;
            logic [5:0]  e_clamp;
            for (int k = 0; k < 8; k++) begin
                e_src[k*3 +: 3] = 3'(m_src[k]);
                e_gain[k] = m_gain[k][0];
                e_mix[k]  = m_mix[k][0];
                e_hiz[k]  = m_hiz[k][0];
            end
            for (int k = 0; k < 6; k++) e_clamp[k] = m_clamp[k][0];
            tests++;
            if ({src_sel, gain_hi, mix_en, out_hiz, clamp_en} !== {e_src, e_gain, e_mix, e_hiz, e_clamp}) begin
                fails++;
                $display("FAIL R5 per-clock model actual=%h/%h/%h/%h/%h expected=%h/%h/%h/%h/%h",
                         src_sel, gain_hi, mix_en, out_hiz, clamp_en,
                         e_src, e_gain, e_mix, e_hiz, e_clamp);
            end
        end
    end

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_d = 1'b1; hp();
        scl_d = 1'b1; hp();
        sda_d = 1'b0; hp();
        scl_d = 1'b0; hp();
    endtask

    task automatic bus_stop();
        sda_d = 1'b0; hp();
        scl_d = 1'b1; hp();
        sda_d = 1'b1; hp();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_d = b[i]; hp();
            scl_d = 1'b1; hp();
            scl_d = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit is_data, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_d = b[i]; hp();
            scl_d = 1'b1; hp();
            if (i == 0) cmp_en = 1'b0;
            scl_d = 1'b0;
        end
        sda_d = 1'b1;
        repeat (ACK_WAIT) @(negedge clk);
        chk(req, int'(sda_oe), int'(exp_ack));
        if (is_data && exp_ack) model_byte(b);
        cmp_en = 1'b1;
        repeat (HP - ACK_WAIT) @(negedge clk);
        scl_d = 1'b1; hp();
        scl_d = 1'b0; hp();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        // R11: reset state
        chk("R11 out_hiz", int'(out_hiz), 8'hFF);
        chk("R11 clamp_en", int'(clamp_en), 6'h3F);
        chk("R11 src_sel", int'(src_sel), 0);
        chk("R11 gain/mix", int'({gain_hi, mix_en}), 0);
        chk("R11 sda_oe", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        cmp_en = 1'b1;

        // R1, R3, R4, R5, R6, R7: point at output 2, select input 5, clamp on, high gain, hiz
        bus_start();
        send_byte(8'h90, 1'b1, 1'b0, "R1 address ack");
        send_byte(8'h40, 1'b1, 1'b1, "R3 ack ptr byte");
        chk("R4 pointer byte keeps hiz", int'(out_hiz[2]), 1);
        send_byte(8'hBB, 1'b1, 1'b1, "R3 ack setting byte");
        bus_stop();
        chk("R5 src of output 2", int'(src_sel[8:6]), 5);
        chk("R6 gain of output 2", int'(gain_hi[2]), 1);
        chk("R7 clamp of input 5", int'(clamp_en[5]), 1);

        // R10: pointer survives STOP/START; R6, R7 low values
        bus_start();
        send_byte(8'h90, 1'b1, 1'b0, "R1 address ack 2");
        send_byte(8'hA1, 1'b1, 1'b1, "R3 ack setting");
        chk("R10 pointer kept, hiz cleared", int'(out_hiz[2]), 0);
        chk("R7 clamp of input 5 freed", int'(clamp_en[5]), 0);
        // R8: reserved source code
        send_byte(8'hCB, 1'b1, 1'b1, "R3 ack reserved");
        chk("R8 src kept", int'(src_sel[8:6]), 5);
        chk("R8 gain applied", int'(gain_hi[2]), 1);
        chk("R8 hiz applied", int'(out_hiz[2]), 1);
        chk("R8 clamp kept", int'(clamp_en), 6'h1F);
        // R9: mixer on output 7 vs output 0
        send_byte(8'hE0, 1'b1, 1'b1, "R3 ack ptr 7");
        send_byte(8'h25, 1'b1, 1'b1, "R3 ack set 7");
        chk("R9 mix on output 7", int'(mix_en[7]), 1);
        chk("R5 src of output 7", int'(src_sel[23:21]), 1);
        send_byte(8'h00, 1'b1, 1'b1, "R3 ack ptr 0");
        send_byte(8'h05, 1'b1, 1'b1, "R3 ack set 0");
        chk("R9 no mix on output 0", int'(mix_en), 8'h80);
        chk("R6 hiz output 0 cleared", int'(out_hiz[0]), 0);
        bus_stop();

        // R2: wrong address, then read bit
        bus_start();
        send_byte(8'h92, 1'b0, 1'b0, "R2 nack other address");
        send_byte(8'h01, 1'b0, 1'b1, "R2 nack ignored data");
        bus_stop();
        chk("R2 ignored byte left output 0 hiz", int'(out_hiz[0]), 0);
        bus_start();
        send_byte(8'h91, 1'b0, 1'b0, "R2 nack read");
        bus_stop();

        // R1: other strap value
        strap = 2'b11;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte(8'h90, 1'b0, 1'b0, "R2 old address refused");
        bus_stop();
        bus_start();
        send_byte(8'h96, 1'b1, 1'b0, "R1 strap 11 ack");
        send_byte(8'h20, 1'b1, 1'b1, "R3 ack ptr 1");
        send_byte(8'h61, 1'b1, 1'b1, "R3 ack set 1");
        bus_stop();
        chk("R5 src of output 1", int'(src_sel[5:3]), 3);
        chk("R7 clamp of input 3", int'(clamp_en[3]), 0);

        // R10: repeated START in the middle of a byte
        bus_start();
        send_byte(8'h96, 1'b1, 1'b0, "R1 strap 11 ack 2");
        send_byte(8'h80, 1'b1, 1'b1, "R3 ack ptr 4");
        send_bits(8'hFF, 4);
        bus_start();
        send_byte(8'h96, 1'b1, 1'b0, "R10 ack after restart");
        send_byte(8'h49, 1'b1, 1'b1, "R10 ack set 4");
        bus_stop();
        chk("R10 src of output 4", int'(src_sel[14:12]), 2);
        chk("R10 gain of output 4", int'(gain_hi[4]), 1);
        chk("R10 output 4 driven", int'(out_hiz[4]), 0);

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule